// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Markers

This block sits between the retirement stage of a core and its memory side. Retired stores enter at an enqueue port and wait in a queue. They leave from the head strictly in the order they arrived. An ordinary store leaves through the data-cache write port once the cache accepts it. A non-temporal store is issued on a separate write-combining port. That path reports each completion later, on its own timing, as a one-cycle pulse. The buffer counts how many non-temporal stores have been issued and not yet completed.

Fence markers share the same queue as barriers. Accepting a fence counts as its retirement, so the producer never waits for a fence to reach the head. A store fence holds back the non-temporal stores behind it until all earlier ones have completed, and it never restrains loads. A full fence lowers a load-permit output while it waits. The permit rises again once everything ahead of the fence has committed or completed. A load fence is accepted and then dropped, because it needs no drain. A registered drained output shows that the queue is empty and that nothing is outstanding on the write-combining path.

Top module: `store_order_buf`

## Requirements
- R1: Entry kinds are coded on enq_kind: 0 ordinary store, 1 non-temporal store, 2 store fence, 3 full fence, and 4 to 7 load fence. Ordinary stores appear on cache_addr/cache_data, and non-temporal stores on wc_addr/wc_data, in exactly the order they were accepted. Only the head entry is ever offered.
- R2: cache_valid is high in every cycle in which an ordinary store is at the head. That store leaves on the edge where cache_accept is high, with no added delay. At most one entry leaves per clock.
- R3: A store fence at the head leaves only in a cycle where the outstanding non-temporal count is zero. No non-temporal store behind it is offered on wc_valid before it has left.
- R4: Enqueuing or holding a store fence never lowers load_permit. load_permit stays high unless a full fence has been accepted.
- R5: After a full fence is accepted, load_permit is low from the next cycle. It stays low until the cycle after that fence leaves the head. A full fence leaves only when the outstanding non-temporal count is zero, and it never raises cache_valid.
- R6: Fences are accepted as soon as they are presented. enq_ready depends only on the queue's occupancy, never on a fence waiting at the head.
- R7: A load fence is acknowledged by enq_ready, takes no queue slot, and has no effect on load_permit, drained or either write port.
- R8: enq_ready is low while DEPTH entries are held. An enqueue attempt made while it is low is discarded.
- R9: The outstanding count rises on each wc_valid with wc_accept and falls on each wc_done pulse. A pulse is ignored when the count is zero. wc_valid stays low while the count equals MAX_NT.
- R10: After a synchronous reset the queue is empty, the outstanding count is zero, and load_permit, drained and enq_ready are high while cache_valid and wc_valid are low.
- R11: drained is high in a cycle exactly when the preceding edge left the queue empty and the outstanding count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Entry presented for enqueue |
| enq_ready | output | 1 | Buffer can take an entry |
| enq_kind | input | 3 | Entry kind code (see R1) |
| enq_addr | input | AW | Store address |
| enq_data | input | DW | Store data |
| cache_valid | output | 1 | Ordinary store offered to the cache |
| cache_accept | input | 1 | Cache takes the offered store |
| cache_addr | output | AW | Address of the offered store |
| cache_data | output | DW | Data of the offered store |
| wc_valid | output | 1 | Non-temporal store offered to the write-combining path |
| wc_accept | input | 1 | Write-combining path takes the offered store |
| wc_addr | output | AW | Address of the offered non-temporal store |
| wc_data | output | DW | Data of the offered non-temporal store |
| wc_done | input | 1 | One non-temporal store has completed (pulse) |
| load_permit | output | 1 | Loads may proceed |
| drained | output | 1 | Queue empty and nothing outstanding |

## Verification
Several things can coincide in one cycle. A completion pulse can arrive in the same cycle as a new non-temporal issue. A full fence can be accepted while an older full fence is retiring. An entry can be pushed in the cycle the head leaves. The directed phases force each pairing. They hold a fence at the head and pulse wc_done on the cycle it becomes free, or they fill the queue while the cache stalls. A random phase then mixes all entry kinds with random accept and completion strobes. A behavioural model keeps a queue of entries and a plain integer count. Its expected outputs are compared with the design on every clock, so a wrong outcome of any collision shows up as a mismatch in the port values of the very next cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // kind of an entry held in the queue (load fences are never stored)
  typedef enum logic [1:0] {
    K_ST = 2'd0,  // ordinary store, leaves through the cache port
    K_NT = 2'd1,  // non-temporal store, leaves through the write-combining port
    K_SF = 2'd2,  // store fence marker
    K_FF = 2'd3   // full fence marker
  } sb_kind_e;

  localparam int KIND_W = 2;

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 66,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count_nx
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM resources
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= count_nx;
    end
  end

  assign count_nx = cnt + CW'(push) - CW'(pop);
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign rdata    = mem[rp];

  // R8: the enqueue gate never lets a push reach a full queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R1: the head controller only releases an entry that exists
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R8: occupancy never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/sb_nt_tracker.sv
module sb_nt_tracker #(
  parameter int MAX_NT = 8,
  localparam int NW    = $clog2(MAX_NT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          done,
  output logic          at_limit,
  output logic          zero,
  output logic [NW-1:0] cnt_nx
);

  logic [NW-1:0] cnt;
  logic          dec;

  assign dec    = done && (cnt != '0);
  assign cnt_nx = cnt + NW'(issue) - NW'(dec);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  assign at_limit = (cnt == NW'(MAX_NT));
  assign zero     = (cnt == '0);

  // R9: the outstanding count stays within its limit
  a_r9_never_past_limit: assert property (@(posedge clk) disable iff (rst)
    cnt <= NW'(MAX_NT));

  // R9: the head controller issues nothing while the limit is reached
  a_r9_no_issue_at_limit: assert property (@(posedge clk) disable iff (rst)
    at_limit |-> !issue);

endmodule

// File: rtl/sb_head_ctl.sv
module sb_head_ctl
  import sb_pkg::*;
(
  input  logic     head_ok,
  input  sb_kind_e head_kind,
  input  logic     nt_zero,
  input  logic     nt_at_limit,
  input  logic     cache_accept,
  input  logic     wc_accept,
  output logic     cache_valid,
  output logic     wc_valid,
  output logic     pop,
  output logic     nt_issue,
  output logic     ff_retire
);

  always_comb begin
    cache_valid = 1'b0;
    wc_valid    = 1'b0;
    pop         = 1'b0;
    nt_issue    = 1'b0;
    ff_retire   = 1'b0;
    if (head_ok) begin
      case (head_kind)
        K_ST: begin
          cache_valid = 1'b1;
          pop         = cache_accept;
        end
        K_NT: begin
          wc_valid = !nt_at_limit;
          nt_issue = !nt_at_limit && wc_accept;
          pop      = !nt_at_limit && wc_accept;
        end
        K_SF: begin
          pop = nt_zero;
        end
        K_FF: begin
          pop       = nt_zero;
          ff_retire = nt_zero;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sb_fence_gate.sv
module sb_fence_gate #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ff_in,
  input  logic ff_out,
  output logic load_permit
);

  logic [CW-1:0] ffc, ffc_nx;

  assign ffc_nx = ffc + CW'(ff_in) - CW'(ff_out);

  always_ff @(posedge clk) begin
    if (rst) begin
      ffc         <= '0;
      load_permit <= 1'b1;
    end else begin
      ffc         <= ffc_nx;
      load_permit <= (ffc_nx == '0);
    end
  end

  // R5: a full fence can only retire if one was counted in
  a_r5_ff_no_underflow: assert property (@(posedge clk) disable iff (rst)
    ff_out |-> (ffc != '0));

endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int MAX_NT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [2:0]    enq_kind,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          cache_valid,
  input  logic          cache_accept,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_data,
  output logic          wc_valid,
  input  logic          wc_accept,
  output logic [AW-1:0] wc_addr,
  output logic [DW-1:0] wc_data,
  input  logic          wc_done,
  output logic          load_permit,
  output logic          drained
);

  localparam int W  = KIND_W + AW + DW;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NW = $clog2(MAX_NT + 1);

  logic          full, empty, push, pop;
  logic [W-1:0]  head;
  logic [CW-1:0] q_cnt_nx;
  logic          nt_zero, nt_at_limit, nt_issue, ff_retire;
  logic [NW-1:0] nt_cnt_nx;
  logic          enq_fire, ff_in;
  sb_kind_e      head_kind;

  assign enq_ready = !full;
  assign enq_fire  = enq_valid && enq_ready;
  // codes 4..7 are load fences: acknowledged, never stored
  assign push      = enq_fire && !enq_kind[2];
  assign ff_in     = push && (enq_kind[1:0] == 2'(K_FF));

  sb_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .wdata    ({enq_kind[1:0], enq_addr, enq_data}),
    .pop      (pop),
    .rdata    (head),
    .full     (full),
    .empty    (empty),
    .count_nx (q_cnt_nx)
  );

  assign head_kind = sb_kind_e'(head[W-1 -: KIND_W]);

  sb_head_ctl u_head (
    .head_ok      (!empty),
    .head_kind    (head_kind),
    .nt_zero      (nt_zero),
    .nt_at_limit  (nt_at_limit),
    .cache_accept (cache_accept),
    .wc_accept    (wc_accept),
    .cache_valid  (cache_valid),
    .wc_valid     (wc_valid),
    .pop          (pop),
    .nt_issue     (nt_issue),
    .ff_retire    (ff_retire)
  );

  sb_nt_tracker #(.MAX_NT(MAX_NT)) u_nt (
    .clk      (clk),
    .rst      (rst),
    .issue    (nt_issue),
    .done     (wc_done),
    .at_limit (nt_at_limit),
    .zero     (nt_zero),
    .cnt_nx   (nt_cnt_nx)
  );

  sb_fence_gate #(.DEPTH(DEPTH)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .ff_in       (ff_in),
    .ff_out      (ff_retire),
    .load_permit (load_permit)
  );

  assign cache_addr = head[DW +: AW];
  assign cache_data = head[DW-1:0];
  assign wc_addr    = head[DW +: AW];
  assign wc_data    = head[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) drained <= 1'b1;
    else     drained <= (q_cnt_nx == '0) && (nt_cnt_nx == '0);
  end

  // R2: an offered store stays offered, unchanged, until the cache takes it
  a_r2_hold_until_accept: assert property (@(posedge clk) disable iff (rst)
    (cache_valid && !cache_accept) |=>
      (cache_valid && $stable(cache_addr) && $stable(cache_data)));

  // R3: an offered non-temporal store is held until taken
  a_r3_nt_hold: assert property (@(posedge clk) disable iff (rst)
    (wc_valid && !wc_accept) |=> (wc_valid && $stable(wc_addr)));

  // R5: accepting a full fence lowers the permit on the next cycle
  a_r5_ff_drops_permit: assert property (@(posedge clk) disable iff (rst)
    (enq_fire && enq_kind == 3'd3) |=> !load_permit);

  // R4, R7: without a new full fence the permit cannot fall
  a_r4_permit_stays_high: assert property (@(posedge clk) disable iff (rst)
    (load_permit && !(enq_fire && enq_kind == 3'd3)) |=> load_permit);

  // R11: a drained buffer offers nothing on either port
  a_r11_drained_idle: assert property (@(posedge clk) disable iff (rst)
    drained |-> (!cache_valid && !wc_valid));

  // R2: at most one entry leaves per clock
  a_r2_single_exit: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cache_valid && cache_accept, nt_issue, ff_retire}));

endmodule

// File: tb/store_order_buf_test.sv
`timescale 1ns/1ps
module store_order_buf_test;

  localparam int DEPTH  = 8;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int MAX_NT = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          enq_valid, enq_ready;
  logic [2:0]    enq_kind;
  logic [AW-1:0] enq_addr, cache_addr, wc_addr;
  logic [DW-1:0] enq_data, cache_data, wc_data;
  logic          cache_valid, cache_accept, wc_valid, wc_accept, wc_done;
  logic          load_permit, drained;

  always #2 clk = ~clk;

  store_order_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MAX_NT(MAX_NT)) uut (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_kind(enq_kind),
    .enq_addr(enq_addr), .enq_data(enq_data),
    .cache_valid(cache_valid), .cache_accept(cache_accept),
    .cache_addr(cache_addr), .cache_data(cache_data),
    .wc_valid(wc_valid), .wc_accept(wc_accept),
    .wc_addr(wc_addr), .wc_data(wc_data), .wc_done(wc_done),
    .load_permit(load_permit), .drained(drained)
  );

  typedef struct {
    logic [1:0]    k;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } ent_t;

  ent_t mq[$];
  int   mntc;
  bit   mperm, mdrn;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model state
  task automatic compare();
    bit ecv, ewv;
    ecv = (mq.size() > 0) && (mq[0].k == 2'd0);
    ewv = (mq.size() > 0) && (mq[0].k == 2'd1) && (mntc < MAX_NT);
    chk(cache_valid == ecv, "R2 cache_valid", 64'(cache_valid), 64'(ecv));
    if (ecv) begin
      chk(cache_addr == mq[0].a, "R1 cache_addr", 64'(cache_addr), 64'(mq[0].a));
      chk(cache_data == mq[0].d, "R1 cache_data", 64'(cache_data), 64'(mq[0].d));
    end
    chk(wc_valid == ewv, "R3 wc_valid", 64'(wc_valid), 64'(ewv));
    if (ewv) chk(wc_addr == mq[0].a, "R1 wc_addr", 64'(wc_addr), 64'(mq[0].a));
    chk(enq_ready == (mq.size() < DEPTH), "R8 enq_ready",
        64'(enq_ready), 64'(mq.size() < DEPTH));
    chk(load_permit == mperm, "R5 load_permit", 64'(load_permit), 64'(mperm));
    chk(drained == mdrn, "R11 drained", 64'(drained), 64'(mdrn));
  endtask

  // one clock: compare, drive, advance model; called and left at a negedge
  task automatic step(input bit ev, input logic [2:0] kd, input logic [31:0] ad,
                      input logic [31:0] da, input bit ca, input bit wa, input bit wd);
    bit fire, pop, issue, dec;
    ent_t e;
    compare();
    enq_valid = ev; enq_kind = kd; enq_addr = ad; enq_data = da;
    cache_accept = ca; wc_accept = wa; wc_done = wd;
    fire = ev && (mq.size() < DEPTH);
    pop = 0; issue = 0;
    if (mq.size() > 0) begin
      case (mq[0].k)
        2'd0: pop = ca;
        2'd1: begin issue = (mntc < MAX_NT) && wa; pop = issue; end
        default: pop = (mntc == 0);
      endcase
    end
    dec = wd && (mntc > 0);
    @(posedge clk);
    if (pop) void'(mq.pop_front());
    if (fire && !kd[2]) begin
      e.k = kd[1:0]; e.a = ad; e.d = da;
      mq.push_back(e);
    end
    mntc = mntc + int'(issue) - int'(dec);
    mperm = 1;
    foreach (mq[i]) if (mq[i].k == 2'd3) mperm = 0;
    mdrn = (mq.size() == 0) && (mntc == 0);
    @(negedge clk);
  endtask

  task automatic idle(input bit ca, input bit wa, input bit wd);
    step(0, 3'd0, 32'h0, 32'h0, ca, wa, wd);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; enq_valid = 0; enq_kind = 0; enq_addr = 0; enq_data = 0;
    cache_accept = 0; wc_accept = 0; wc_done = 0;
    mntc = 0; mperm = 1; mdrn = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R10: reset state
    chk(enq_ready == 1, "R10 enq_ready", 64'(enq_ready), 1);
    chk(load_permit == 1, "R10 load_permit", 64'(load_permit), 1);
    chk(drained == 1, "R10 drained", 64'(drained), 1);
    chk(cache_valid == 0, "R10 cache_valid", 64'(cache_valid), 0);
    chk(wc_valid == 0, "R10 wc_valid", 64'(wc_valid), 0);

    // R3/R4: store fence between two non-temporal stores
    step(1, 3'd1, 32'h100, 32'h11, 0, 1, 0);
    step(1, 3'd2, 32'h0,   32'h0,  0, 1, 0);
    step(1, 3'd1, 32'h200, 32'h22, 0, 1, 0);
    for (int i = 0; i < 3; i++) idle(0, 1, 0);
    chk(wc_valid == 0, "R3 nt behind store fence held", 64'(wc_valid), 0);
    chk(load_permit == 1, "R4 store fence keeps permit", 64'(load_permit), 1);
    idle(0, 0, 1);
    idle(0, 0, 0);
    chk(wc_valid == 1, "R3 nt released after fence", 64'(wc_valid), 1);
    chk(wc_addr == 32'h200, "R3 released nt address", 64'(wc_addr), 64'h200);
    idle(0, 1, 0);
    idle(0, 0, 1);
    chk(drained == 1, "R11 drained after completion", 64'(drained), 1);

    // R7: load fence on an idle buffer leaves everything untouched
    step(1, 3'd4, 32'h300, 32'h33, 0, 0, 0);
    chk(drained == 1, "R7 load fence takes no slot", 64'(drained), 1);
    chk(cache_valid == 0, "R7 load fence not committed", 64'(cache_valid), 0);
    chk(load_permit == 1, "R7 load fence keeps permit", 64'(load_permit), 1);

    // R5: full fence behind a stalled non-temporal store
    step(1, 3'd1, 32'h400, 32'h44, 0, 0, 0);
    step(1, 3'd3, 32'h0,   32'h0,  0, 0, 0);
    chk(load_permit == 0, "R5 permit low after full fence", 64'(load_permit), 0);
    step(1, 3'd6, 32'h0, 32'h0, 0, 0, 0);
    chk(load_permit == 0, "R7 load fence does not release", 64'(load_permit), 0);
    idle(0, 1, 0);
    idle(0, 0, 0);
    chk(load_permit == 0, "R5 permit low while nt outstanding", 64'(load_permit), 0);
    chk(cache_valid == 0, "R5 full fence not on cache port", 64'(cache_valid), 0);
    idle(0, 0, 1);
    idle(0, 0, 0);
    idle(0, 0, 0);
    chk(load_permit == 1, "R5 permit back after fence retires", 64'(load_permit), 1);

    // R6/R8: fences accepted behind a stalled store, then fill
    step(1, 3'd0, 32'h500, 32'h55, 0, 0, 0);
    step(1, 3'd2, 32'h0,   32'h0,  0, 0, 0);
    step(1, 3'd3, 32'h0,   32'h0,  0, 0, 0);
    chk(enq_ready == 1, "R6 fences accepted without wait", 64'(enq_ready), 1);
    for (int i = 0; i < 5; i++) step(1, 3'd0, 32'h600 + i, 32'h60 + i, 0, 0, 0);
    chk(enq_ready == 0, "R8 ready low when full", 64'(enq_ready), 0);
    step(1, 3'd0, 32'hdead, 32'hdead, 0, 0, 0);
    while (!mdrn) idle(1, 1, mntc > 0);
    chk(drained == 1, "R8 discarded entry never appears", 64'(drained), 1);

    // R9: outstanding limit
    for (int i = 0; i < MAX_NT + 1; i++) step(1, 3'd1, 32'h700 + i, 32'h70 + i, 0, 1, 0);
    for (int i = 0; i < 3; i++) idle(0, 1, 0);
    chk(wc_valid == 0, "R9 no issue at limit", 64'(wc_valid), 0);
    idle(0, 0, 1);
    chk(wc_valid == 1, "R9 issue after completion", 64'(wc_valid), 1);
    while (!mdrn) idle(1, 1, mntc > 0);

    // random mix of all kinds and strobes
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] kd;
      r = $urandom_range(0, 99);
      kd = (r < 40) ? 3'd0 : (r < 65) ? 3'd1 : (r < 75) ? 3'd2 :
           (r < 85) ? 3'd3 : 3'(4 + $urandom_range(0, 3));
      step($urandom_range(0, 99) < 60, kd, $urandom, $urandom,
           $urandom_range(0, 99) < 70, $urandom_range(0, 99) < 70,
           (mntc > 0) && ($urandom_range(0, 99) < 40));
    end

    while (!mdrn) idle(1, 1, mntc > 0);
    compare();
    chk(drained == 1, "R11 drained at end", 64'(drained), 1);
    chk(load_permit == 1, "R5 permit high at end", 64'(load_permit), 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule